// File: doc/BRIEF.md
# Output Voltage Setpoint Sequencer

This block keeps the output-voltage command of a regulator and turns it into a digital reference that moves one step at a time. The regulator loop follows that reference. A host writes a 16-bit command word through a simple strobe port, and each write is acknowledged. The block applies the trim offset and the two margin scale factors to form the effective target. Writes that would take the output outside the limit window are clamped, and the block raises a sticky warning and a one-cycle notify pulse when that happens.

The block sequences the rail through four phases: off, soft-start, regulation and soft-stop. When the rail is enabled, the reference climbs from zero to the boot value at the soft-start rate. A write that arrives during that climb is stored but only acted on once the climb ends. In regulation, every accepted write steers the reference at once toward the new target at the transition rate. Disabling the rail ramps the reference back to zero at the soft-stop rate. A fault or the reset pin puts the command back to the boot value.

Top module: `vout_setpoint_seq`

## Requirements
- R1: After reset the reference is 0, the phase is off (code 0), the stored command equals `boot_val`, and both `warn` and `notify` are low.
- R2: A write stores `wr_data[12:0]`. Bits 15:13 are ignored and always read back as zero on `cmd_rd`. `wr_ack` is high for exactly the one cycle after every `wr_en` cycle.
- R3: Let `wr_data[12:0] + trim` be the sum. If the sum is above `vmax`, the command becomes `vmax`. If it is below `vmin`, the command becomes `vmin`. In either case `warn` is set and `notify` is high for exactly one cycle.
- R4: `warn` stays set until a `clr_warn` strobe. In-range writes do not clear it.
- R5: The effective target is computed as follows:
  - Start from command + trim.
  - With `margin_hi` set, add floor(command × `mhi_scale` / 256) − command.
  - With `margin_lo` set, subtract command − floor(command × `mlo_scale` / 256).
  - Saturate the result to 0..8191.
- R6: The reference moves by one LSB per (rate + 1) cycles toward its target. It never overshoots and never changes by more than one LSB per cycle, except when a fault drops it to 0.
- R7: Enabling the rail enters soft-start (phase 1). The reference rises from 0 to `boot_val` at `ss_rate`. Writes in this phase are stored but do not redirect the ramp. The block then enters regulation (phase 2) and moves to the effective target at `tr_rate`.
- R8: In regulation, a write during an ongoing transition redirects the ramp on the next step. The block does not wait for the earlier transition to end.
- R9: Disabling the rail enters soft-stop (phase 3), and the reference falls to 0 at `stop_rate`. Writes in this phase are acknowledged but discarded. When the reference reaches 0, the phase becomes off and the command is reloaded with `boot_val`.
- R10: A fault forces the phase to off, the reference to 0 and the command to `boot_val` on the next edge.
- R11: With `vrst_enable` high, a low `vrst_n` reloads the command with `boot_val`, and the reference heads back to it. With `vrst_enable` low, the pin has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_data | input | 16 | Command write data |
| wr_en | input | 1 | Write strobe |
| wr_ack | output | 1 | Write acknowledge, one cycle after the strobe |
| rail_en | input | 1 | Rail enable |
| fault | input | 1 | Fault indication |
| vrst_n | input | 1 | Active-low reset pin |
| vrst_enable | input | 1 | Enables the reset-pin function |
| margin_hi | input | 1 | Margin-high select |
| margin_lo | input | 1 | Margin-low select |
| boot_val | input | 13 | Boot command value |
| trim | input | 14 | Signed trim offset in LSB |
| vmax | input | 13 | Upper command limit |
| vmin | input | 13 | Lower command limit |
| mhi_scale | input | 10 | Margin-high factor, 8 fractional bits |
| mlo_scale | input | 10 | Margin-low factor, 8 fractional bits |
| ss_rate | input | 16 | Soft-start cycles per step minus one |
| stop_rate | input | 16 | Soft-stop cycles per step minus one |
| tr_rate | input | 16 | Transition cycles per step minus one |
| clr_warn | input | 1 | Clears the sticky warning |
| cmd_rd | output | 16 | Stored command readback |
| vref | output | 13 | Current reference value |
| phase | output | 2 | 0 off, 1 soft-start, 2 regulation, 3 soft-stop |
| warn | output | 1 | Sticky max/min warning |
| notify | output | 1 | One-cycle host-notify pulse |

## Verification
`cmd_rd`, `wr_ack`, `notify` and `warn` are due one clock edge after the edge that samples a write. The bench drives each write on a falling edge and reads these outputs at the next falling edge. A phase change caused by `rail_en` or `fault` also shows one edge later. The R10 zero reference is read at that same point. The reference itself advances every rate + 1 edges. Step spacing is measured by counting falling edges between successive changes. Final values are awaited by polling with a bounded wait of a few thousand cycles and then compared with the expected target. To check redirection, the bench tracks the highest value seen after a write, which may exceed the value at the time of the write by at most the one step already in flight.

// File: rtl/vout_setpoint_seq.sv
module vout_setpoint_seq #(
  parameter int CW   = 13,
  parameter int DW   = 16,
  parameter int FRAC = 8,
  parameter int SW   = FRAC + 2,
  parameter int RW   = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [DW-1:0]       wr_data,
  input  logic                wr_en,
  output logic                wr_ack,
  input  logic                rail_en,
  input  logic                fault,
  input  logic                vrst_n,
  input  logic                vrst_enable,
  input  logic                margin_hi,
  input  logic                margin_lo,
  input  logic [CW-1:0]       boot_val,
  input  logic signed [CW:0]  trim,
  input  logic [CW-1:0]       vmax,
  input  logic [CW-1:0]       vmin,
  input  logic [SW-1:0]       mhi_scale,
  input  logic [SW-1:0]       mlo_scale,
  input  logic [RW-1:0]       ss_rate,
  input  logic [RW-1:0]       stop_rate,
  input  logic [RW-1:0]       tr_rate,
  input  logic                clr_warn,
  output logic [DW-1:0]       cmd_rd,
  output logic [CW-1:0]       vref,
  output logic [1:0]          phase,
  output logic                warn,
  output logic                notify
);
  localparam int TOP = (1 << CW) - 1;

  typedef enum logic [1:0] {PH_OFF, PH_START, PH_RUN, PH_STOP} phase_t;

  phase_t          st_q;
  logic [CW-1:0]   cmd_q, vref_q, eff, tgt;
  logic [RW-1:0]   cnt_q, rate;
  logic            warn_q, notify_q, ack_q;
  logic signed [CW+2:0] wsum, hi_lim, lo_lim;

  wire rst_pin = vrst_enable && !vrst_n;
  wire acc_wr  = wr_en && !fault && !rst_pin && (st_q != PH_STOP);

  assign wsum   = {3'b000, wr_data[CW-1:0]} + {{2{trim[CW]}}, trim};
  assign hi_lim = {3'b000, vmax};
  assign lo_lim = {3'b000, vmin};

  always_comb begin
    int c, e;
    c = int'(cmd_q);
    e = c + int'(trim);
    if (margin_hi) e = e + ((c * int'(mhi_scale)) >>> FRAC) - c;
    if (margin_lo) e = e - (c - ((c * int'(mlo_scale)) >>> FRAC));
    if (e < 0) e = 0;
    else if (e > TOP) e = TOP;
    eff = e[CW-1:0];
  end

  always_comb begin
    case (st_q)
      PH_START: begin tgt = boot_val; rate = ss_rate;   end
      PH_RUN:   begin tgt = eff;      rate = tr_rate;   end
      PH_STOP:  begin tgt = '0;       rate = stop_rate; end
      default:  begin tgt = '0;       rate = '0;        end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= PH_OFF;
      cmd_q    <= boot_val;
      vref_q   <= '0;
      cnt_q    <= '0;
      warn_q   <= 1'b0;
      notify_q <= 1'b0;
      ack_q    <= 1'b0;
    end else begin
      ack_q    <= wr_en;
      notify_q <= 1'b0;
      if (clr_warn) warn_q <= 1'b0;
      if (acc_wr) begin
        if (wsum > hi_lim) begin
          cmd_q <= vmax; warn_q <= 1'b1; notify_q <= 1'b1;
        end else if (wsum < lo_lim) begin
          cmd_q <= vmin; warn_q <= 1'b1; notify_q <= 1'b1;
        end else begin
          cmd_q <= wr_data[CW-1:0];
        end
      end
      if (rst_pin) cmd_q <= boot_val;

      if (vref_q == tgt) cnt_q <= '0;
      else if (cnt_q >= rate) begin
        cnt_q  <= '0;
        vref_q <= (vref_q > tgt) ? vref_q - 1'b1 : vref_q + 1'b1;
      end else cnt_q <= cnt_q + 1'b1;

      case (st_q)
        PH_OFF:   if (rail_en) st_q <= PH_START;
        PH_START: if (!rail_en) st_q <= PH_STOP;
                  else if (vref_q == boot_val) st_q <= PH_RUN;
        PH_RUN:   if (!rail_en) st_q <= PH_STOP;
        PH_STOP:  if (vref_q == '0) begin
                    st_q  <= PH_OFF;
                    cmd_q <= boot_val;
                  end
        default:  st_q <= PH_OFF;
      endcase

      if (fault) begin
        st_q   <= PH_OFF;
        vref_q <= '0;
        cnt_q  <= '0;
        cmd_q  <= boot_val;
      end
    end
  end

  assign cmd_rd = {{(DW-CW){1'b0}}, cmd_q};
  assign vref   = vref_q;
  assign phase  = st_q;
  assign warn   = warn_q;
  assign notify = notify_q;
  assign wr_ack = ack_q;

  assert_clamp_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && (wsum > hi_lim)) |=> (cmd_q == $past(vmax) && warn_q && notify_q));

  assert_clamp_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && (wsum < lo_lim) && !(wsum > hi_lim)) |=> (cmd_q == $past(vmin) && warn_q && notify_q));

  assert_warn_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (warn_q && !clr_warn) |=> warn_q);

  assert_single_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !fault |=> (vref_q == $past(vref_q) || vref_q == $past(vref_q) + 1'b1 ||
                vref_q == $past(vref_q) - 1'b1));

  assert_stop_falls_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PH_STOP) |=> (vref_q <= $past(vref_q)));

  assert_fault_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> (vref_q == '0 && st_q == PH_OFF && cmd_q == $past(boot_val)));

endmodule

// File: tb/vout_setpoint_seq_tb_top.sv
module vout_setpoint_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] wr_data = '0;
  logic wr_en = 1'b0, rail_en = 1'b0, fault = 1'b0, vrst_n = 1'b1, vrst_enable = 1'b0;
  logic margin_hi = 1'b0, margin_lo = 1'b0, clr_warn = 1'b0;
  logic [12:0] boot_val = 13'd1200, vmax = 13'd1600, vmin = 13'd800;
  logic signed [13:0] trim = '0;
  logic [9:0] mhi_scale = 10'd256, mlo_scale = 10'd256;
  logic [15:0] ss_rate = 16'd2, stop_rate = 16'd1, tr_rate = 16'd1;
  logic wr_ack, warn, notify;
  logic [15:0] cmd_rd;
  logic [12:0] vref;
  logic [1:0] phase;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  vout_setpoint_seq dut_i (
    .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wr_en(wr_en), .wr_ack(wr_ack),
    .rail_en(rail_en), .fault(fault), .vrst_n(vrst_n), .vrst_enable(vrst_enable),
    .margin_hi(margin_hi), .margin_lo(margin_lo), .boot_val(boot_val), .trim(trim),
    .vmax(vmax), .vmin(vmin), .mhi_scale(mhi_scale), .mlo_scale(mlo_scale),
    .ss_rate(ss_rate), .stop_rate(stop_rate), .tr_rate(tr_rate), .clr_warn(clr_warn),
    .cmd_rd(cmd_rd), .vref(vref), .phase(phase), .warn(warn), .notify(notify)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] d);
    wr_data = d; wr_en = 1'b1;
    tick(1);
    wr_en = 1'b0;
  endtask

  task automatic settle(input int exp, input int lim);
    for (int i = 0; i < lim; i++) begin
      if (int'(vref) == exp) break;
      tick(1);
    end
  endtask

  function automatic int eff_fn(int c, int t, bit h, bit l, int mh, int ml);
    int e = c + t;
    if (h) e = e + (c * mh) / 256 - c;
    if (l) e = e - (c - (c * ml) / 256);
    if (e < 0) e = 0;
    if (e > 8191) e = 8191;
    return e;
  endfunction

  function automatic int clamp_fn(int w, int t, int hi, int lo);
    if (w + t > hi) return hi;
    if (w + t < lo) return lo;
    return w;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int t0, sp, vmx, vw, ecmd, eff;
    bit ewarn, cl;
    void'($urandom(32'd7));
    tick(3);
    rst_n = 1'b1;
    tick(1);
    chk(vref == 0, "R1 vref", vref, 0);
    chk(phase == 0, "R1 phase", phase, 0);
    chk(cmd_rd == 1200, "R1 cmd", cmd_rd, 1200);
    chk(!warn && !notify, "R1 warn", warn, 0);

    wr(16'hE000 | 16'd1000);
    chk(cmd_rd == 1000, "R2 upper bits ignored", cmd_rd, 1000);
    chk(wr_ack == 1'b1, "R2 ack", wr_ack, 1);
    tick(1);
    chk(wr_ack == 1'b0, "R2 ack single", wr_ack, 0);

    rail_en = 1'b1;
    tick(1);
    chk(phase == 1, "R7 soft-start phase", phase, 1);
    while (vref == 0) tick(1);
    t0 = 0;
    while (vref == 1) begin tick(1); t0++; end
    chk(t0 == 3, "R6 soft-start step spacing", t0, 3);
    wr(16'd1100);
    chk(cmd_rd == 1100, "R7 write stored in soft-start", cmd_rd, 1100);
    vmx = 0;
    for (int i = 0; i < 5000 && phase == 1; i++) begin
      if (vref > vmx) vmx = vref;
      tick(1);
    end
    chk(vmx <= 1200, "R7 ramp held to boot", vmx, 1200);
    chk(phase == 2 && vref == 1200, "R7 regulation at boot", vref, 1200);
    settle(1100, 3000);
    chk(vref == 1100, "R7 moves to stored command", vref, 1100);

    tr_rate = 16'd3;
    wr(16'd1500);
    tick(40);
    vw = vref;
    wr(16'd1050);
    vmx = 0;
    for (int i = 0; i < 3000 && vref != 1050; i++) begin
      if (vref > vmx) vmx = vref;
      tick(1);
    end
    chk(vmx <= vw + 1, "R8 retarget without finishing", vmx, vw + 1);
    chk(vref == 1050, "R8 reaches new target", vref, 1050);
    t0 = 0;
    wr(16'd1060);
    while (vref == 1050) tick(1);
    sp = vref;
    while (int'(vref) == sp) begin tick(1); t0++; end
    chk(t0 == 4, "R6 transition step spacing", t0, 4);
    tr_rate = 16'd1;

    wr(16'd2000);
    chk(cmd_rd == 1600, "R3 clamp high", cmd_rd, 1600);
    chk(warn && notify, "R3 warn/notify", notify, 1);
    tick(1);
    chk(!notify, "R3 notify pulse", notify, 0);
    wr(16'd100);
    chk(cmd_rd == 800, "R3 clamp low", cmd_rd, 800);
    wr(16'd1000);
    chk(warn == 1'b1, "R4 warn sticky", warn, 1);
    clr_warn = 1'b1; tick(1); clr_warn = 1'b0;
    chk(warn == 1'b0, "R4 warn cleared", warn, 0);

    ewarn = 1'b0;
    for (int it = 0; it < 30; it++) begin
      trim      = 14'($signed($urandom_range(80)) - 40);
      margin_hi = 1'($urandom_range(1));
      margin_lo = 1'($urandom_range(1));
      mhi_scale = 10'($urandom_range(282, 230));
      mlo_scale = 10'($urandom_range(282, 230));
      tr_rate   = 16'($urandom_range(1));
      vw = int'($urandom_range(1700, 700));
      ecmd = clamp_fn(vw, int'(trim), 1600, 800);
      cl = (ecmd != vw);
      ewarn = ewarn | cl;
      wr(16'(vw));
      chk(int'(cmd_rd) == ecmd, "R3 random clamp", cmd_rd, ecmd);
      chk(notify == cl, "R3 random notify", notify, cl);
      chk(warn == ewarn, "R4 random warn", warn, ewarn);
      eff = eff_fn(ecmd, int'(trim), margin_hi, margin_lo, int'(mhi_scale), int'(mlo_scale));
      settle(eff, 5000);
      chk(int'(vref) == eff, "R5 effective target", vref, eff);
      if ($urandom_range(1) == 1) begin
        clr_warn = 1'b1; tick(1); clr_warn = 1'b0; ewarn = 1'b0;
      end
    end
    trim = '0; margin_hi = 1'b0; margin_lo = 1'b0; tr_rate = 16'd1;

    wr(16'd1400);
    settle(1400, 3000);
    vrst_n = 1'b0; tick(1); vrst_n = 1'b1;
    chk(cmd_rd == 1400, "R11 pin ignored when disabled", cmd_rd, 1400);
    vrst_enable = 1'b1; vrst_n = 1'b0; tick(1); vrst_n = 1'b1;
    chk(cmd_rd == 1200, "R11 pin reloads boot", cmd_rd, 1200);
    settle(1200, 3000);
    chk(vref == 1200, "R11 output back at boot", vref, 1200);
    vrst_enable = 1'b0;

    wr(16'd1300);
    settle(1300, 3000);
    rail_en = 1'b0;
    tick(1);
    chk(phase == 3, "R9 soft-stop phase", phase, 3);
    wr(16'd900);
    chk(wr_ack == 1'b1, "R9 write acked in soft-stop", wr_ack, 1);
    chk(cmd_rd == 1300, "R9 write discarded", cmd_rd, 1300);
    for (int i = 0; i < 4000 && phase != 0; i++) tick(1);
    chk(phase == 0 && vref == 0, "R9 stop ends at zero", vref, 0);
    chk(cmd_rd == 1200, "R9 reload boot", cmd_rd, 1200);

    rail_en = 1'b1;
    for (int i = 0; i < 5000 && phase != 2; i++) tick(1);
    wr(16'd1000);
    tick(20);
    fault = 1'b1;
    tick(1);
    chk(vref == 0 && phase == 0, "R10 fault off", vref, 0);
    chk(cmd_rd == 1200, "R10 fault reload", cmd_rd, 1200);
    fault = 1'b0;
    tick(2);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule